// File: doc/BRIEF.md
# Source Interconnect Mode Controller

This block runs the connection handshake on the sending end of a point-to-point parallel link. A two-bit mode word from the host picks one of three behaviours: clear (reset), wait, or run. The block drives the outgoing interconnect line toward the far end, watches the incoming interconnect line from the far end, and reports to the host whether the far end may be treated as present. It also produces the enable that switches on the sender's functional interfaces.

The incoming line is asynchronous to the local clock and passes through a flop chain before any decision uses it. The presence flag is deliberately hard to raise. It rises only in wait mode after the host has held wait mode through a period in which the incoming line was seen low, or at the moment the mode steps from clear straight into run while the incoming line is already high. It drops as soon as the synchronized incoming line goes low, whatever the mode. Moving from wait into run keeps the current flag.

Top module: `src_link_ctrl`

## Requirements
- R1: `link_out` is 1 one clock edge after `mode_sel` is sampled as 2'b10 (wait) or 2'b11 (run), and 0 one edge after it is sampled as 2'b00 or 2'b01.
- R2: `fn_enable` is 1 one edge after `mode_sel` is sampled as 2'b11 and 0 one edge after any other value.
- R3: `peer_link_in` passes through SYNC_STAGES (default 2) flops; in wait mode with the interlock armed, a rise of the input raises `peer_avail` on the third clock edge after it, not before.
- R4: While `rst_n` is low, and one edge after `mode_sel` is sampled as 2'b00 or the reserved 2'b01, `link_out`, `fn_enable` and `peer_avail` are 0 and the wait-mode interlock is disarmed; an active peer line has no effect in these modes.
- R5: In wait mode `peer_avail` does not rise while the synchronized peer line has stayed high since wait mode was entered without an intervening low.
- R6: In wait mode, once the synchronized peer line has been seen low, a later high raises `peer_avail`.
- R7: When `mode_sel` moves from 2'b00 or 2'b01 to 2'b11, `peer_avail` becomes 1 if the synchronized peer line is high at that edge and stays 0 otherwise.
- R8: While `mode_sel` stays 2'b11, `peer_avail` never rises.
- R9: A move from wait to run keeps `peer_avail` unchanged.
- R10: `peer_avail` falls one edge after the synchronized peer line is low, in every mode.
- R11: When a clear mode and a wait-mode acceptance meet at the same edge, the clear wins: `peer_avail` stays 0 and the interlock is disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Host mode: 00 clear, 01 reserved (clear), 10 wait, 11 run |
| peer_link_in | input | 1 | Interconnect line from the far end, asynchronous |
| link_out | output | 1 | Interconnect line driven toward the far end |
| fn_enable | output | 1 | Enable for the sender's functional interfaces |
| peer_avail | output | 1 | Far end reported present to the host |

## Verification
The hazardous coincidence is a mode change landing in the same cycle as the peer line's synchronized rise: the bench times a rise so that it reaches the synchronizer output exactly when the mode is dropped to clear, and judges that the flag stays low and that returning to wait with the line still high does not raise it. The step from wait to run coinciding with a high peer line is walked in the vector table and is judged by the flag keeping its previous value instead of being set. The synchronizer latency is pinned by sampling the flag after each of the first three edges following the input rise.

// File: rtl/slc_pkg.sv
package slc_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_CLEAR = 2'b00,
    MODE_RSVD  = 2'b01,
    MODE_WAIT  = 2'b10,
    MODE_RUN   = 2'b11
  } link_mode_e;

  // Upper bit set means the outgoing line is driven.
  function automatic logic mode_drives_link(input link_mode_e m);
    return m[MODE_W-1];
  endfunction

  // Clear and reserved both wipe state.
  function automatic logic mode_is_clear(input link_mode_e m);
    return !m[MODE_W-1];
  endfunction

  function automatic logic mode_is_run(input link_mode_e m);
    return m == MODE_RUN;
  endfunction

  function automatic logic mode_is_wait(input link_mode_e m);
    return m == MODE_WAIT;
  endfunction

  // Step from a clear mode straight into run.
  function automatic logic boot_entry(input link_mode_e cur, input link_mode_e prev);
    return mode_is_run(cur) && mode_is_clear(prev);
  endfunction

endpackage

// File: rtl/slc_sync.sv
module slc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end

      // R3: each stage carries the previous stage one edge later
      p_stage_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[i] == $past(chain_q[i-1]));
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/slc_mode_regs.sv
module slc_mode_regs
  import slc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_in,
  output logic              link_q,
  output logic              fn_q,
  output logic [MODE_W-1:0] prev_mode
);

  link_mode_e mode_cur;
  link_mode_e prev_q;

  assign mode_cur = link_mode_e'(mode_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      fn_q   <= 1'b0;
      prev_q <= MODE_CLEAR;
    end else begin
      link_q <= mode_drives_link(mode_cur);
      fn_q   <= mode_is_run(mode_cur);
      prev_q <= mode_cur;
    end
  end

  assign prev_mode = prev_q;

  // R1: wait or run drives the outgoing line next edge
  p_link_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b10 || mode_in == 2'b11) |=> link_q);

  // R1 / R4: clear or reserved releases the line next edge
  p_link_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b00 || mode_in == 2'b01) |=> !link_q);

  // R2: functional enable only after run was sampled
  p_fn_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b11) |=> fn_q);

  p_fn_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in != 2'b11) |=> !fn_q);

endmodule

// File: rtl/slc_avail_track.sv
module slc_avail_track
  import slc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [MODE_W-1:0] prev_mode,
  input  logic              peer_sync,
  output logic              avail
);

  link_mode_e mode_cur;
  link_mode_e mode_prev;
  logic       seen_low_q;

  // Named events, brought out for the assertions.
  logic evt_clear;
  logic evt_drop;
  logic evt_wait_accept;
  logic evt_boot_accept;
  logic evt_arm;

  assign mode_cur  = link_mode_e'(mode_in);
  assign mode_prev = link_mode_e'(prev_mode);

  assign evt_clear       = mode_is_clear(mode_cur);
  assign evt_drop        = !evt_clear && !peer_sync;
  assign evt_arm         = mode_is_wait(mode_cur) && !peer_sync;
  assign evt_wait_accept = mode_is_wait(mode_cur) && peer_sync && seen_low_q;
  assign evt_boot_accept = boot_entry(mode_cur, mode_prev) && peer_sync;

  // Interlock: set by a low peer line seen in wait mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_low_q <= 1'b0;
    else if (evt_clear) seen_low_q <= 1'b0;
    else if (evt_arm)   seen_low_q <= 1'b1;
  end

  // Presence flag: clear beats drop beats either acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  avail <= 1'b0;
    else if (evt_clear)                          avail <= 1'b0;
    else if (evt_drop)                           avail <= 1'b0;
    else if (evt_wait_accept || evt_boot_accept) avail <= 1'b1;
  end

  // R4 / R11: clear modes force the flag low next edge
  p_clear_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b00 || mode_in == 2'b01) |=> !avail);

  // R11: clear modes disarm the interlock
  p_clear_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b00 || mode_in == 2'b01) |=> !seen_low_q);

  // R10: a low synchronized peer line drops the flag in any mode
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !peer_sync |=> !avail);

  // R5 / R7 / R8: the flag rises only in wait or on entry to run from clear
  p_rise_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail) |-> ($past(mode_in) == 2'b10 ||
                      ($past(mode_in) == 2'b11 && !$past(prev_mode[1]))));

  // R5: a rise in wait mode needs an armed interlock
  p_interlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(avail) && $past(mode_in) == 2'b10) |-> $past(seen_low_q));

  // R9: wait to run keeps the flag while the peer line is high
  p_wait_to_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b11 && prev_mode == 2'b10 && peer_sync) |=> (avail == $past(avail)));

endmodule

// File: rtl/src_link_ctrl.sv
module src_link_ctrl
  import slc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              peer_link_in,
  output logic              link_out,
  output logic              fn_enable,
  output logic              peer_avail
);

  logic              peer_sync;
  logic [MODE_W-1:0] prev_mode;

  slc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (peer_link_in),
    .dout  (peer_sync)
  );

  slc_mode_regs u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_in   (mode_sel),
    .link_q    (link_out),
    .fn_q      (fn_enable),
    .prev_mode (prev_mode)
  );

  slc_avail_track u_avail (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_in   (mode_sel),
    .prev_mode (prev_mode),
    .peer_sync (peer_sync),
    .avail     (peer_avail)
  );

  // R2: enable never active without the outgoing line
  p_fn_implies_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fn_enable |-> link_out);

endmodule

// File: tb/src_link_ctrl_test.sv
module src_link_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int NVEC       = 18;

  typedef struct packed {
    logic [1:0] mode;
    logic       peer;
    logic [2:0] exp;   // {link_out, fn_enable, peer_avail}
    logic [3:0] req;
  } vec_t;

  // Walked in order; each step settles SETTLE edges before sampling.
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 1'b0, 3'b000, 4'd4},  // R4 idle clear
    '{2'b00, 1'b1, 3'b000, 4'd4},  // R4 active peer ignored in clear
    '{2'b10, 1'b1, 3'b100, 4'd5},  // R5 wait, never saw low
    '{2'b10, 1'b0, 3'b100, 4'd10}, // R10 low arms interlock, flag low
    '{2'b10, 1'b1, 3'b101, 4'd6},  // R6 accepted
    '{2'b11, 1'b1, 3'b111, 4'd9},  // R9 wait to run keeps 1
    '{2'b11, 1'b0, 3'b110, 4'd10}, // R10 drop in run
    '{2'b11, 1'b1, 3'b110, 4'd8},  // R8 no rise while in run
    '{2'b01, 1'b1, 3'b000, 4'd4},  // R4 reserved acts as clear
    '{2'b11, 1'b1, 3'b111, 4'd7},  // R7 entry from clear, peer high
    '{2'b00, 1'b0, 3'b000, 4'd4},  // R4 clear
    '{2'b11, 1'b0, 3'b110, 4'd7},  // R7 entry from clear, peer low
    '{2'b11, 1'b1, 3'b110, 4'd8},  // R8 later high ignored
    '{2'b10, 1'b1, 3'b100, 4'd5},  // R5 interlock was cleared earlier
    '{2'b11, 1'b1, 3'b110, 4'd9},  // R9 wait to run keeps 0
    '{2'b10, 1'b0, 3'b100, 4'd1},  // R1 wait drives the line
    '{2'b10, 1'b1, 3'b101, 4'd6},  // R6 accepted again
    '{2'b11, 1'b0, 3'b110, 4'd2}   // R2 run enables, R10 drop
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       peer_link_in = 1'b0;
  logic       link_out;
  logic       fn_enable;
  logic       peer_avail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  src_link_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .peer_link_in (peer_link_in),
    .link_out     (link_out),
    .fn_enable    (fn_enable),
    .peer_avail   (peer_avail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {link,fn,avail} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic sample_after(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R4: outputs low while reset is held, even with run and peer high
    mode_sel     = 2'b11;
    peer_link_in = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R4 reset", {link_out, fn_enable, peer_avail}, 3'b000);
    @(negedge clk);
    mode_sel     = 2'b00;
    peer_link_in = 1'b0;
    rst_n        = 1'b1;

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      mode_sel     = VECS[i].mode;
      peer_link_in = VECS[i].peer;
      sample_after(SETTLE);
      check($sformatf("R%0d vec%0d", VECS[i].req, i),
            {link_out, fn_enable, peer_avail}, VECS[i].exp);
    end

    // R3: synchronizer latency; arm interlock in wait with peer low
    @(negedge clk);
    mode_sel     = 2'b00;
    peer_link_in = 1'b0;
    sample_after(SETTLE);
    @(negedge clk);
    mode_sel = 2'b10;
    sample_after(SETTLE);
    @(negedge clk);
    peer_link_in = 1'b1;
    sample_after(1);
    check("R3 edge1", {link_out, fn_enable, peer_avail}, 3'b100);
    sample_after(1);
    check("R3 edge2", {link_out, fn_enable, peer_avail}, 3'b100);
    sample_after(1);
    check("R3 edge3", {link_out, fn_enable, peer_avail}, 3'b101);

    // R4: asynchronous reset mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R4 async", {link_out, fn_enable, peer_avail}, 3'b000);
    @(negedge clk);
    rst_n        = 1'b1;
    mode_sel     = 2'b00;
    peer_link_in = 1'b0;
    sample_after(SETTLE);

    // R11: clear mode lands on the edge the wait acceptance would occur
    @(negedge clk);
    mode_sel = 2'b10;
    sample_after(SETTLE);
    @(negedge clk);
    peer_link_in = 1'b1;          // synchronized high after edge 2
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    mode_sel = 2'b00;             // edge 3: acceptance meets clear
    sample_after(1);
    check("R11 collide", {link_out, fn_enable, peer_avail}, 3'b000);
    @(negedge clk);
    mode_sel = 2'b10;             // peer still high, interlock disarmed
    sample_after(SETTLE);
    check("R11 disarmed", {link_out, fn_enable, peer_avail}, 3'b100);

    // R1 / R2: one-edge response of the line and enable
    @(negedge clk);
    mode_sel = 2'b11;
    sample_after(1);
    check("R2 run one edge", {link_out, fn_enable, peer_avail}, 3'b110);
    @(negedge clk);
    mode_sel = 2'b01;
    sample_after(1);
    check("R1 release one edge", {link_out, fn_enable, peer_avail}, 3'b000);

    finish_run();
  end

endmodule